// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a real page frame by walking a chain of translation tables held in memory. A 64-bit control element selects where the walk begins: at a region-first, region-second or region-third table, or directly at a segment table. The walk then steps down through the remaining region levels, the segment table and finally a page table. Each step is one 8-byte read on a simple request/response memory port, and only one read is outstanding at a time.

A walk starts with a one-cycle start pulse. It ends with a one-cycle done pulse. At that point the block presents one of two results. On success it gives the real page frame and a flag that says whether stores are allowed. On failure it gives a fault class and a 64-bit exception code. A control element flagged as real-space skips the tables entirely. A segment entry can also end the walk early with a 1 MB frame when large frames are enabled. Each result stays on the outputs until the next walk completes.

Top module: `pt_walker`

## Requirements
- R1: When control-element bit 5 (real-space) is set, the walk makes no memory reads. The page-aligned virtual address (bits 11:0 cleared) comes back as the frame, with writeOk 1, faultValid 0 and excCode 0.
- R2: Control-element bits 3:2 give the start level: 3 region-first, 2 region-second, 1 region-third, 0 segment. If any of the following virtual bits is set, the block raises fault class 1 (address-space type) with no reads: bits 63:53 for a level-2 start, bits 63:42 for level 1, bits 63:31 for level 0.
- R3: The first index sits at virtual bits 63:53, 52:42, 41:31 or 30:20 for start levels 3, 2, 1 and 0. If its top two bits exceed control-element bits 1:0 (table length), the block raises with no reads the translation fault of the start level. The fault classes are 2 for region-first, 3 for region-second, 4 for region-third and 5 for segment.
- R4: Table origins are bits 63:12 of the control element and of region entries, and bits 63:11 of segment entries. Each read address is the origin plus 8 times the 11-bit index of that level; for the page table the index is virtual bits 19:12. A clean walk makes one read per level from the start level down to the page table. The frame it returns is page-entry bits 63:12, with bits 11:0 zero.
- R5: A region or segment entry with bit 5 (invalid) set raises the translation fault of the table it was read from. An entry whose bits 3:2 differ from that table's level raises fault class 7 (specification).
- R6: For a region entry at level L, the top two bits of the level L-1 index must be at least entry bits 7:6 (offset) and at most entry bits 1:0 (length). Otherwise the block raises the translation fault of level L-1.
- R7: A segment entry with bit 10 set while largeEn is 1 ends the walk without a page read. The frame is entry bits 63:20 joined to virtual bits 19:12. With largeEn 0, bit 10 has no effect.
- R8: A page entry with bit 10 set raises fault class 6 (page translation). A page entry with bit 8 (reserved) set raises fault class 7.
- R9: Bit 9 (read-only) clears writeOk when it is set in the segment entry, in the page entry, or in a region entry while largeEn is 1. A store walk that would end without write permission reports fault class 8 (protection). On any fault, writeOk and frameOut are 0.
- R10: On a fault, excCode is built from four parts. It starts with the page-aligned virtual address. It then adds 0x400 for a store or 0x800 otherwise, and adds 4 for class 8. Finally ascCode is placed in bits 1:0.
- R11: A walk holds exactly one read outstanding. A start pulse while busy is ignored. done is high for exactly one cycle per accepted start.
- R12: After reset, busy, done, memReq, faultValid, writeOk, faultClass, frameOut and excCode are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle request to begin a walk |
| vaIn | input | 64 | Virtual address, bits 11:0 ignored |
| ctlElem | input | 64 | Address-space control element |
| ascCode | input | 2 | Address-space code reported in the exception code |
| isStore | input | 1 | Access is a store |
| largeEn | input | 1 | Enables 1 MB segment frames and region read-only bits |
| memReq | output | 1 | One-cycle read request |
| memAddr | output | 64 | Byte address of the 8-byte entry |
| memRdata | input | 64 | Entry returned by memory |
| memRvalid | input | 1 | memRdata is valid, one pulse per request |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| frameOut | output | 64 | Real frame address |
| writeOk | output | 1 | Stores allowed to the frame |
| faultValid | output | 1 | Last walk ended in a fault |
| faultClass | output | 4 | Fault class, 0 when none |
| excCode | output | 64 | Exception code, 0 when none |

## Verification
The hardest outcomes to reach from the ports are the mid-chain range and type faults. They need a region entry whose offset or length field excludes the next index, and that requires a consistent table chain built behind the fault. The bench builds a fresh table image for every combination of start level, injected defect, access kind and large-frame setting. It chooses index values whose top two bits land exactly on or beyond the field limits, and derives each expected result by walking the same image under the stated rules. A second start pulse is also injected mid-walk, with a different address and a real-space element, to show that the running walk is not disturbed.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W       = 64;
  localparam int ENT_W      = 64;
  localparam int PAGE_SHIFT = 12;
  localparam int PX_W       = 8;
  localparam int IDX_W      = 11;
  localparam int ENT_SHIFT  = 3;
  localparam int SEG_SHIFT  = PAGE_SHIFT + PX_W;
  localparam int PT_SHIFT   = PX_W + ENT_SHIFT;

  // control element and region/segment entry layout
  localparam int CE_REAL  = 5;
  localparam int LEN_LO   = 0;
  localparam int TYP_LO   = 2;
  localparam int INV_BIT  = 5;
  localparam int OFF_LO   = 6;
  localparam int RO_BIT   = 9;
  localparam int FC_BIT   = 10;
  // page entry layout
  localparam int PG_RSV   = 8;
  localparam int PG_RO    = 9;
  localparam int PG_INV   = 10;

  localparam logic [VA_W-1:0] PAGE_MASK = {{(VA_W-PAGE_SHIFT){1'b1}}, {PAGE_SHIFT{1'b0}}};
  localparam logic [VA_W-1:0] PT_MASK   = {{(VA_W-PT_SHIFT){1'b1}}, {PT_SHIFT{1'b0}}};
  localparam logic [VA_W-1:0] BIG_MASK  = {{(VA_W-SEG_SHIFT){1'b1}}, {SEG_SHIFT{1'b0}}};
  localparam logic [VA_W-1:0] EXC_STORE = VA_W'(64'h400);
  localparam logic [VA_W-1:0] EXC_OTHER = VA_W'(64'h800);
  localparam logic [VA_W-1:0] EXC_PROT  = VA_W'(64'h4);

  typedef enum logic [3:0] {
    FC_NONE = 4'd0, FC_ASCE_TYPE = 4'd1, FC_R1 = 4'd2, FC_R2 = 4'd3,
    FC_R3 = 4'd4, FC_SEG = 4'd5, FC_PAGE = 4'd6, FC_SPEC = 4'd7, FC_PROT = 4'd8
  } fault_e;

  typedef struct packed {
    logic load;
    logic issue;
    logic take;
  } strobe_t;

  typedef struct packed {
    logic startEnd;
    logic entryEnd;
  } status_t;

  function automatic int unsigned idxLsb(input logic [1:0] lvl);
    return SEG_SHIFT + IDX_W * int'(lvl);
  endfunction

  function automatic logic [IDX_W-1:0] tblIdx(input logic [VA_W-1:0] va, input logic [1:0] lvl);
    logic [VA_W-1:0] s;
    s = va >> idxLsb(lvl);
    return s[IDX_W-1:0];
  endfunction

  function automatic logic [1:0] topTwo(input logic [VA_W-1:0] va, input logic [1:0] lvl);
    logic [VA_W-1:0] s;
    s = va >> (idxLsb(lvl) + IDX_W - 2);
    return s[1:0];
  endfunction

  function automatic logic spaceOverflow(input logic [VA_W-1:0] va, input logic [1:0] lvl);
    if (lvl == 2'd3) return 1'b0;
    return (va >> (idxLsb(lvl) + IDX_W)) != '0;
  endfunction

  function automatic fault_e transFault(input logic [1:0] lvl);
    case (lvl)
      2'd3:    return FC_R1;
      2'd2:    return FC_R2;
      2'd1:    return FC_R3;
      default: return FC_SEG;
    endcase
  endfunction

  function automatic logic [VA_W-1:0] excValue(input logic [VA_W-1:0] va, input logic st,
                                               input logic prot, input logic [1:0] asc);
    return va | (st ? EXC_STORE : EXC_OTHER) | (prot ? EXC_PROT : '0) | {{(VA_W-2){1'b0}}, asc};
  endfunction
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    memRvalid,
  input  status_t sts,
  output strobe_t stb,
  output logic    memReq,
  output logic    busy,
  output logic    done
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;
  state_e stR, stN;

  always_comb begin
    stN = stR;
    stb = '0;
    case (stR)
      S_IDLE: if (startReq) begin
        stb.load = 1'b1;
        stN = sts.startEnd ? S_DONE : S_ISSUE;
      end
      S_ISSUE: begin
        stb.issue = 1'b1;
        stN = S_WAIT;
      end
      S_WAIT: if (memRvalid) begin
        stb.take = 1'b1;
        stN = sts.entryEnd ? S_DONE : S_ISSUE;
      end
      default: stN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stR <= S_IDLE;
    else       stR <= stN;
  end

  assign memReq = stb.issue;
  assign busy   = (stR != S_IDLE);
  assign done   = (stR == S_DONE);

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R11: a request is always followed by a wait, never a second request
  p_req_gap_r11: assert property (@(posedge clk) disable iff (!rstN) memReq |=> !memReq);
  // R11: a start while busy never reloads the walk
  p_busy_no_load_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |-> !stb.load);
endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [VA_W-1:0]  vaIn,
  input  logic [VA_W-1:0]  ctlElem,
  input  logic [1:0]       ascCode,
  input  logic             isStore,
  input  logic             largeEn,
  input  logic [ENT_W-1:0] memRdata,
  output logic [VA_W-1:0]  memAddr,
  output status_t          sts,
  output logic [VA_W-1:0]  frameOut,
  output logic             writeOk,
  output logic             faultValid,
  output logic [3:0]       faultClass,
  output logic [VA_W-1:0]  excCode
);
  // walk state
  logic [VA_W-1:0] vaR, originR;
  logic [1:0]      lvlR, ascR;
  logic            storeR, largeR, wrR, pageR;
  // result state
  logic [VA_W-1:0] frameR, excR;
  logic            wrOutR, fvR;
  fault_e          fcR;

  // start checks, evaluated on the inputs in the load cycle
  logic [VA_W-1:0] vaNew;
  logic [1:0]      lvlNew;
  logic            startReal;
  fault_e          startFault;

  always_comb begin
    vaNew      = vaIn & PAGE_MASK;
    lvlNew     = ctlElem[TYP_LO +: 2];
    startReal  = ctlElem[CE_REAL];
    startFault = FC_NONE;
    if (!startReal) begin
      if (spaceOverflow(vaNew, lvlNew))
        startFault = FC_ASCE_TYPE;
      else if (topTwo(vaNew, lvlNew) > ctlElem[LEN_LO +: 2])
        startFault = transFault(lvlNew);
    end
  end

  assign sts.startEnd = startReal || (startFault != FC_NONE);

  // entry decode, evaluated on the returned entry in the take cycle
  logic            entEnd, wrNext, pageNext;
  fault_e          entFault;
  logic [VA_W-1:0] frameNext, originNext;
  logic [1:0]      lvlNext, nextTop;

  always_comb begin
    entEnd     = 1'b0;
    entFault   = FC_NONE;
    wrNext     = wrR;
    frameNext  = '0;
    originNext = originR;
    lvlNext    = lvlR;
    pageNext   = pageR;
    nextTop    = topTwo(vaR, lvlR - 2'd1);
    if (pageR) begin
      entEnd = 1'b1;
      if (memRdata[PG_INV])      entFault = FC_PAGE;
      else if (memRdata[PG_RSV]) entFault = FC_SPEC;
      else begin
        wrNext    = wrR & ~memRdata[PG_RO];
        frameNext = memRdata & PAGE_MASK;
      end
    end else if (memRdata[INV_BIT]) begin
      entEnd   = 1'b1;
      entFault = transFault(lvlR);
    end else if (memRdata[TYP_LO +: 2] != lvlR) begin
      entEnd   = 1'b1;
      entFault = FC_SPEC;
    end else if (lvlR == 2'd0) begin
      wrNext = wrR & ~memRdata[RO_BIT];
      if (memRdata[FC_BIT] && largeR) begin
        entEnd    = 1'b1;
        frameNext = (memRdata & BIG_MASK) | (vaR & ~BIG_MASK);
      end else begin
        pageNext   = 1'b1;
        originNext = memRdata & PT_MASK;
      end
    end else if ((nextTop < memRdata[OFF_LO +: 2]) || (nextTop > memRdata[LEN_LO +: 2])) begin
      entEnd   = 1'b1;
      entFault = transFault(lvlR - 2'd1);
    end else begin
      wrNext     = wrR & ~(largeR & memRdata[RO_BIT]);
      originNext = memRdata & PAGE_MASK;
      lvlNext    = lvlR - 2'd1;
    end
    if (entEnd && (entFault == FC_NONE) && storeR && !wrNext)
      entFault = FC_PROT;
  end

  assign sts.entryEnd = entEnd;

  // read address for the current step
  always_comb begin
    if (pageR)
      memAddr = originR + {{(VA_W-PX_W-ENT_SHIFT){1'b0}}, vaR[SEG_SHIFT-1:PAGE_SHIFT], {ENT_SHIFT{1'b0}}};
    else
      memAddr = originR + ({{(VA_W-IDX_W){1'b0}}, tblIdx(vaR, lvlR)} << ENT_SHIFT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaR <= '0; originR <= '0; lvlR <= '0; ascR <= '0;
      storeR <= 1'b0; largeR <= 1'b0; wrR <= 1'b0; pageR <= 1'b0;
      frameR <= '0; excR <= '0; wrOutR <= 1'b0; fvR <= 1'b0; fcR <= FC_NONE;
    end else if (stb.load) begin
      vaR     <= vaNew;
      originR <= ctlElem & PAGE_MASK;
      lvlR    <= lvlNew;
      ascR    <= ascCode;
      storeR  <= isStore;
      largeR  <= largeEn;
      wrR     <= 1'b1;
      pageR   <= 1'b0;
      if (sts.startEnd) begin
        fvR    <= (startFault != FC_NONE);
        fcR    <= startFault;
        frameR <= (startFault == FC_NONE) ? vaNew : '0;
        wrOutR <= (startFault == FC_NONE);
        excR   <= (startFault == FC_NONE) ? '0 : excValue(vaNew, isStore, 1'b0, ascCode);
      end
    end else if (stb.take) begin
      wrR     <= wrNext;
      originR <= originNext;
      lvlR    <= lvlNext;
      pageR   <= pageNext;
      if (entEnd) begin
        fvR    <= (entFault != FC_NONE);
        fcR    <= entFault;
        frameR <= (entFault == FC_NONE) ? frameNext : '0;
        wrOutR <= (entFault == FC_NONE) && wrNext;
        excR   <= (entFault == FC_NONE) ? '0 : excValue(vaR, storeR, entFault == FC_PROT, ascR);
      end
    end
  end

  assign frameOut   = frameR;
  assign writeOk    = wrOutR;
  assign faultValid = fvR;
  assign faultClass = fcR;
  assign excCode    = excR;

  // R4: every entry address is 8-byte aligned
  p_addr_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.issue |-> (memAddr[ENT_SHIFT-1:0] == '0));
  // R11: the latched address only changes when a new walk is accepted
  p_va_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(vaR));
  // R9: a protection fault only follows a store walk
  p_prot_store_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.take && sts.entryEnd) |=> (fcR != FC_PROT) || storeR);
  // R9: a faulted walk never reports write permission
  p_fault_no_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.take && sts.entryEnd) |=> !(fvR && writeOk));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic [63:0] vaIn,
  input  logic [63:0] ctlElem,
  input  logic [1:0]  ascCode,
  input  logic        isStore,
  input  logic        largeEn,
  output logic        memReq,
  output logic [63:0] memAddr,
  input  logic [63:0] memRdata,
  input  logic        memRvalid,
  output logic        busy,
  output logic        done,
  output logic [63:0] frameOut,
  output logic        writeOk,
  output logic        faultValid,
  output logic [3:0]  faultClass,
  output logic [63:0] excCode
);
  strobe_t stb;
  status_t sts;

  ptw_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .memRvalid(memRvalid),
    .sts(sts), .stb(stb), .memReq(memReq), .busy(busy), .done(done)
  );

  ptw_dpath uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .vaIn(vaIn), .ctlElem(ctlElem),
    .ascCode(ascCode), .isStore(isStore), .largeEn(largeEn), .memRdata(memRdata),
    .memAddr(memAddr), .sts(sts), .frameOut(frameOut), .writeOk(writeOk),
    .faultValid(faultValid), .faultClass(faultClass), .excCode(excCode)
  );
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [63:0] vaIn = '0, ctlElem = '0;
  logic [1:0]  ascCode = '0;
  logic        isStore = 1'b0, largeEn = 1'b0;
  logic        memReq, memRvalid;
  logic [63:0] memAddr, memRdata;
  logic        busy, done, writeOk, faultValid;
  logic [63:0] frameOut, excCode;
  logic [3:0]  faultClass;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .vaIn(vaIn), .ctlElem(ctlElem),
    .ascCode(ascCode), .isStore(isStore), .largeEn(largeEn), .memReq(memReq),
    .memAddr(memAddr), .memRdata(memRdata), .memRvalid(memRvalid), .busy(busy),
    .done(done), .frameOut(frameOut), .writeOk(writeOk), .faultValid(faultValid),
    .faultClass(faultClass), .excCode(excCode)
  );

  // sparse table memory
  logic [63:0] mem [logic [63:0]];

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  int          reads;
  int          lat;
  logic [63:0] pendAddr;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memRvalid <= 1'b0; memRdata <= '0; lat <= 0; reads <= 0; pendAddr <= '0;
    end else begin
      memRvalid <= 1'b0;
      if (memReq) begin
        pendAddr <= memAddr;
        lat      <= 1 + (reads % 3);
        reads    <= reads + 1;
      end else if (lat != 0) begin
        lat <= lat - 1;
        if (lat == 1) begin
          memRvalid <= 1'b1;
          memRdata  <= rd(pendAddr);
        end
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFail = nFail + 1;
      $display("FAIL R11 watchdog act=%0d exp=%0d", cycles, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks = nChecks + 1;
    if (act !== exp) begin
      nFail = nFail + 1;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // expected walk, derived from the requirements
  task automatic refWalk(input logic [63:0] va, input logic [63:0] ctl, input logic [1:0] asc,
                         input logic st, input logic lg, output logic [63:0] frame,
                         output logic wr, output logic [3:0] cls, output logic [63:0] exc,
                         output int nr);
    logic [63:0] v, org, e;
    int lvl;
    logic fin;
    logic [1:0] nt;
    v = va & ~64'hFFF; lvl = int'(ctl[3:2]); org = ctl & ~64'hFFF;
    frame = '0; wr = 1'b1; cls = 4'd0; exc = '0; nr = 0; fin = 1'b0;
    if (ctl[5]) begin
      frame = v;
      return;
    end
    if (lvl < 3 && (v >> (31 + 11 * lvl)) != 0) begin cls = 4'd1; fin = 1'b1; end
    else if (((v >> (29 + 11 * lvl)) & 64'h3) > {62'b0, ctl[1:0]}) begin cls = 4'(5 - lvl); fin = 1'b1; end
    while (!fin) begin
      e = rd(org + (((v >> (20 + 11 * lvl)) & 64'h7FF) << 3)); nr++;
      if (e[5]) begin cls = 4'(5 - lvl); fin = 1'b1; end
      else if (int'(e[3:2]) != lvl) begin cls = 4'd7; fin = 1'b1; end
      else if (lvl == 0) begin
        if (e[9]) wr = 1'b0;
        if (e[10] && lg) frame = (e & ~64'hFFFFF) | (v & 64'hFF000);
        else begin
          org = e & ~64'h7FF;
          e = rd(org + (((v >> 12) & 64'hFF) << 3)); nr++;
          if (e[10]) cls = 4'd6;
          else if (e[8]) cls = 4'd7;
          else begin
            if (e[9]) wr = 1'b0;
            frame = e & ~64'hFFF;
          end
        end
        fin = 1'b1;
      end else begin
        nt = 2'((v >> (29 + 11 * (lvl - 1))) & 64'h3);
        if (nt < e[7:6] || nt > e[1:0]) begin cls = 4'(5 - (lvl - 1)); fin = 1'b1; end
        else begin
          if (lg && e[9]) wr = 1'b0;
          org = e & ~64'hFFF;
          lvl = lvl - 1;
        end
      end
    end
    if (cls == 4'd0 && st && !wr) cls = 4'd8;
    if (cls != 4'd0) begin
      frame = '0; wr = 1'b0;
      exc = v | (st ? 64'h400 : 64'h800) | (cls == 4'd8 ? 64'h4 : 64'h0) | {62'b0, asc};
    end
  endtask

  // start one walk and sample its result at the done pulse
  task automatic runWalk(input logic [63:0] va, input logic [63:0] ctl, input logic [1:0] asc,
                         input logic st, input logic lg, output int nr, output logic gotDone,
                         output logic pulseOk);
    int r0;
    int cyc;
    @(negedge clk);
    vaIn = va; ctlElem = ctl; ascCode = asc; isStore = st; largeEn = lg;
    startReq = 1'b1; r0 = reads;
    @(negedge clk);
    startReq = 1'b0;
    cyc = 0;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    gotDone = done;
    nr = reads - r0;
    @(negedge clk);
    pulseOk = !done;
  endtask

  localparam logic [63:0] PT_ORG = 64'h0080_0800;
  localparam logic [63:0] FRM    = 64'h0123_4000;
  localparam logic [63:0] BIG    = 64'h0770_0000;

  function automatic logic [63:0] orgOf(input int l);
    return 64'h0010_0000 * 64'(l + 1);
  endfunction

  function automatic string tagOf(input int k);
    case (k)
      0: return "R4";  1: return "R5";  2: return "R5";  3: return "R8";
      4: return "R5";  5: return "R8";  6: return "R9";  7: return "R9";
      8: return "R7";  9: return "R6";  10: return "R6"; 11: return "R3";
      12: return "R2"; default: return "R1";
    endcase
  endfunction

  // build a table image for start level t and defect variant k
  task automatic buildCase(input int t, input int k, input logic st,
                           output logic [63:0] va, output logic [63:0] ctl);
    logic [10:0] ix [4];
    logic [7:0]  px;
    logic [63:0] e;
    mem.delete();
    ix[3] = 11'(k * 41 + 1);
    ix[2] = 11'(k * 3 + 9);
    ix[1] = 11'(k * 29 + 17);
    ix[0] = 11'(k * 13 + 5 + (st ? 100 : 0));
    px    = 8'(k * 7 + 3);
    if (k == 9 && t > 0)  ix[t-1][10:9] = 2'b01;
    if (k == 10 && t > 0) ix[t-1][10:9] = 2'b10;
    if (k == 11)          ix[t][10:9]   = 2'b01;
    va = 64'hABC | ({56'b0, px} << 12);
    for (int l = 0; l <= t; l++) va = va | ({53'b0, ix[l]} << (20 + 11 * l));
    if (k == 12) va[63] = 1'b1;
    ctl = orgOf(t) | (64'(t) << 2) | (k == 11 ? 64'h0 : 64'h3);
    if (k == 13) ctl = ctl | 64'h20;
    for (int l = t; l >= 1; l--) begin
      e = orgOf(l - 1) | (64'(l) << 2) | 64'h3;
      if (l == t) begin
        if (k == 1)  e = e | 64'h20;
        if (k == 4)  e = (e & ~64'hC) | (64'((t + 1) % 4) << 2);
        if (k == 9)  e = e | 64'hC0;
        if (k == 10) e = e & ~64'h3;
        if (k == 7)  e = e | 64'h200;
      end
      mem[orgOf(l) + {50'b0, ix[l], 3'b0}] = e;
    end
    e = (k == 8) ? (BIG | 64'h400) : PT_ORG;
    if (k == 2 || (t == 0 && k == 1)) e = e | 64'h20;
    if (t == 0 && k == 4) e = e | 64'h4;
    if (t == 0 && k == 7) e = e | 64'h200;
    mem[orgOf(0) + {50'b0, ix[0], 3'b0}] = e;
    e = FRM;
    if (k == 3) e = e | 64'h400;
    if (k == 5) e = e | 64'h100;
    if (k == 6) e = e | 64'h200;
    mem[PT_ORG + {53'b0, px, 3'b0}] = e;
  endtask

  initial begin
    logic [63:0] va, ctl, eFrame, eExc;
    logic        eWr, gd, po;
    logic [3:0]  eCls;
    int          eNr, nr, doneCnt;

    // R12: reset state
    #5;
    chk("R12", "busy", {63'b0, busy}, 64'h0);
    chk("R12", "done", {63'b0, done}, 64'h0);
    chk("R12", "memReq", {63'b0, memReq}, 64'h0);
    chk("R12", "faultValid", {63'b0, faultValid}, 64'h0);
    chk("R12", "frameOut", frameOut, 64'h0);
    chk("R12", "excCode|class|wr", excCode | {59'b0, writeOk, faultClass}, 64'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: real-space element, hand-computed
    mem.delete();
    runWalk(64'h1234_5678_9ABC_D123, 64'h20, 2'd2, 1'b1, 1'b0, nr, gd, po);
    chk("R1", "frame", frameOut, 64'h1234_5678_9ABC_D000);
    chk("R1", "reads", 64'(nr), 64'h0);
    chk("R1", "writeOk", {63'b0, writeOk}, 64'h1);
    chk("R1", "faultValid", {63'b0, faultValid}, 64'h0);

    // R2: segment start with bit 31 set, hand-computed
    runWalk(64'h8000_0000, 64'h0010_0003, 2'd0, 1'b0, 1'b0, nr, gd, po);
    chk("R2", "class", {60'b0, faultClass}, 64'h1);
    chk("R10", "exc", excCode, 64'h8000_0800);
    chk("R2", "reads", 64'(nr), 64'h0);

    // R9 R10: read-only page, store then load, hand-computed
    mem.delete();
    mem[64'h0010_0018] = 64'h0080_0800;
    mem[64'h0080_0828] = 64'h0123_4200;
    runWalk(64'h0030_5000, 64'h0010_0003, 2'd1, 1'b1, 1'b0, nr, gd, po);
    chk("R9", "class", {60'b0, faultClass}, 64'h8);
    chk("R10", "exc", excCode, 64'h0030_5405);
    chk("R4", "reads", 64'(nr), 64'h2);
    runWalk(64'h0030_5000, 64'h0010_0003, 2'd1, 1'b0, 1'b0, nr, gd, po);
    chk("R9", "frame", frameOut, 64'h0123_4000);
    chk("R9", "writeOk", {63'b0, writeOk}, 64'h0);
    chk("R9", "faultValid", {63'b0, faultValid}, 64'h0);

    // R11: start pulse during a walk is ignored
    buildCase(3, 0, 1'b0, va, ctl);
    refWalk(va, ctl, 2'd3, 1'b0, 1'b0, eFrame, eWr, eCls, eExc, eNr);
    @(negedge clk);
    vaIn = va; ctlElem = ctl; ascCode = 2'd3; isStore = 1'b0; largeEn = 1'b0; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    @(negedge clk);
    vaIn = 64'hFFFF_0000_0000_0000; ctlElem = 64'h20; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    doneCnt = 0;
    for (int c = 0; c < 80; c++) begin
      if (done) doneCnt++;
      @(negedge clk);
    end
    chk("R11", "done count", 64'(doneCnt), 64'h1);
    chk("R11", "frame of first walk", frameOut, eFrame);
    chk("R11", "busy after", {63'b0, busy}, 64'h0);

    // sweep: start level, defect, access kind, large frames
    for (int t = 0; t < 4; t++) begin
      for (int k = 0; k < 14; k++) begin
        for (int s = 0; s < 2; s++) begin
          for (int g = 0; g < 2; g++) begin
            buildCase(t, k, s[0], va, ctl);
            refWalk(va, ctl, 2'(k), s[0], g[0], eFrame, eWr, eCls, eExc, eNr);
            runWalk(va, ctl, 2'(k), s[0], g[0], nr, gd, po);
            chk(tagOf(k), "done seen", {63'b0, gd}, 64'h1);
            chk("R11", "done one cycle", {63'b0, po}, 64'h1);
            chk(tagOf(k), "class", {60'b0, faultClass}, {60'b0, eCls});
            chk(tagOf(k), "faultValid", {63'b0, faultValid}, {63'b0, eCls != 4'd0});
            chk(tagOf(k), "frame", frameOut, eFrame);
            chk("R9", "writeOk", {63'b0, writeOk}, {63'b0, eWr});
            chk("R10", "exc", excCode, eExc);
            chk("R4", "reads", 64'(nr), 64'(eNr));
          end
        end
      end
    end

    summary();
    $finish;
  end
endmodule